// File: doc/BRIEF.md
# Acknowledged Transaction Sequencer

This block is the control sequencer that carries out a complete acknowledged radio exchange with no help from the host. In transmit use, the host loads the packet and its length into the transmit path and then pulses a start command. The sequencer switches on the oscillator and waits for it to settle. It then switches on the synthesizer and waits for that to settle. Next it tells the transmit engine to send the data packet. When the engine reports the packet as sent, the sequencer turns the receiver on and waits for a handshake. The exchange ends when an acknowledgement arrives or when a programmable wait runs out. Each of these two outcomes sets its own status flag. The block then falls back to a low-power state, either sleep or idle, chosen by a configuration input.

In receive-transaction use, a level input keeps the block listening. When a valid packet arrives, the sequencer raises a one-cycle interrupt and has the transmit engine send an acknowledgement from its fixed acknowledgement source. It then goes back to listening. The acknowledgement traffic never touches the data buffers in either direction. The transmit engine is pointed at the acknowledgement source, and the receive buffer write enable is held off while an acknowledgement is awaited.

Top module: `ack_txn_seq`

## Requirements
- R1: Out of reset, sleep_o is 1 and busy_o, xtal_en_o, synth_en_o, rx_en_o, tx_req_o, ack_ok_o, timeout_o and irq_o are all 0.
- R2: A go_i pulse in a low-power state starts a transmit transaction. On the next cycle busy_o and xtal_en_o are 1, and ack_ok_o and timeout_o are cleared.
- R3: Power-up takes this many cycles: xtal_en_o alone is on for osc_wait_i+1 cycles, then synth_en_o is also on for pll_wait_i+1 cycles, then tx_req_o pulses for exactly one cycle with tx_ack_sel_o=0 (data packet).
- R4: After tx_done_i, rx_en_o is 1 while the block waits for an acknowledgement. An rx_ack_i pulse in that window sets ack_ok_o and ends the transaction on the next cycle.
- R5: If no acknowledgement comes within ack_wait_i+1 cycles of waiting, timeout_o is set, ack_ok_o stays 0, and the transaction ends. An acknowledgement in the last cycle of the window counts as success.
- R6: A transaction ends in sleep (sleep_o=1) when end_idle_i=0, and in idle (sleep_o=0, busy_o=0) when end_idle_i=1.
- R7: In a low-power state with rx_mode_i=1 and no go_i, the block powers up with the same timing as R3 and then listens with rx_en_o=1. It issues no transmit request while listening.
- R8: A valid packet (rx_pkt_i) while listening gives a one-cycle irq_o pulse and, in that same cycle, a one-cycle tx_req_o with tx_ack_sel_o=1 (acknowledgement source). After tx_done_i the block listens again.
- R9: rx_buf_we_o follows rx_byte_vld_i only while listening. It is 0 while an acknowledgement is awaited or being sent, so acknowledgement traffic leaves the data buffers unchanged.
- R10: go_i is ignored while busy_o=1. The transaction timing and status flags do not change.
- R11: When go_i and rx_mode_i are both high in a low-power state, go_i wins and a transmit transaction with a data packet runs.
- R12: Dropping rx_mode_i while listening returns the block to its low-power state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start a transmit transaction |
| rx_mode_i | input | 1 | Receive-transaction mode enable (level) |
| end_idle_i | input | 1 | 1: end in idle, 0: end in sleep |
| osc_wait_i | input | CNT_W | Oscillator settle count |
| pll_wait_i | input | CNT_W | Synthesizer settle count |
| ack_wait_i | input | CNT_W | Acknowledgement timeout count |
| tx_done_i | input | 1 | Transmit engine finished the packet |
| rx_ack_i | input | 1 | Valid acknowledgement received |
| rx_pkt_i | input | 1 | Valid data packet received |
| rx_byte_vld_i | input | 1 | Received byte valid from the receive engine |
| xtal_en_o | output | 1 | Oscillator enable |
| synth_en_o | output | 1 | Synthesizer enable |
| tx_req_o | output | 1 | One-cycle transmit start to the engine |
| tx_ack_sel_o | output | 1 | 1: transmit from the acknowledgement source |
| rx_en_o | output | 1 | Receiver enable |
| rx_buf_we_o | output | 1 | Receive data buffer write enable |
| busy_o | output | 1 | Transaction in progress |
| sleep_o | output | 1 | Block is in sleep |
| ack_ok_o | output | 1 | Last transaction was acknowledged |
| timeout_o | output | 1 | Last transaction timed out |
| irq_o | output | 1 | One-cycle packet-received interrupt |

## Verification
The bench counts settle cycles while go_i is held high through the whole power-up. A design that restarted on a repeated go_i would stretch those counts, and an off-by-one counter would shorten or lengthen them. It places the acknowledgement on the final cycle of the wait window. A design that checked the timeout first would report a timeout instead of success. It keeps rx_byte_vld_i high during the acknowledgement wait and during the acknowledgement send, which catches a receive buffer that would be corrupted by handshake bytes. It also raises go_i and rx_mode_i together, where a wrong priority would send an acknowledgement-sourced packet. The scoreboard checks the source select of every transmit request against the queue of expected requests.

// File: rtl/ack_seq_pkg.sv
package ack_seq_pkg;
  typedef enum logic [3:0] {
    ST_SLEEP, ST_IDLE, ST_XTAL, ST_SYNTH, ST_TX_KICK, ST_TX_WAIT,
    ST_ACK_WAIT, ST_LISTEN, ST_ACK_KICK, ST_ACK_SEND
  } seq_st_e;
endpackage

// File: rtl/ack_seq_timer.sv
module ack_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ack_seq_fsm.sv
module ack_seq_fsm
  import ack_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             rx_mode_i,
  input  logic             end_idle_i,
  input  logic [CNT_W-1:0] osc_wait_i,
  input  logic [CNT_W-1:0] pll_wait_i,
  input  logic [CNT_W-1:0] ack_wait_i,
  input  logic             tx_done_i,
  input  logic             rx_ack_i,
  input  logic             rx_pkt_i,
  input  logic             tmr_zero_i,
  output seq_st_e          st_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             tmr_dec_o,
  output logic             ev_go_o,
  output logic             ev_ack_o,
  output logic             ev_to_o,
  output logic             ev_pkt_o
);
  seq_st_e st_q, st_d;
  logic    rxm_q, rxm_d;
  seq_st_e rest_st;

  assign rest_st = end_idle_i ? ST_IDLE : ST_SLEEP;

  always_comb begin
    st_d       = st_q;
    rxm_d      = rxm_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    tmr_dec_o  = 1'b0;
    ev_go_o    = 1'b0;
    ev_ack_o   = 1'b0;
    ev_to_o    = 1'b0;
    ev_pkt_o   = 1'b0;
    unique case (st_q)
      ST_SLEEP, ST_IDLE: begin
        if (go_i) begin
          // go outranks receive mode
          st_d = ST_XTAL; rxm_d = 1'b0; ev_go_o = 1'b1;
          tmr_load_o = 1'b1; tmr_val_o = osc_wait_i;
        end else if (rx_mode_i) begin
          st_d = ST_XTAL; rxm_d = 1'b1;
          tmr_load_o = 1'b1; tmr_val_o = osc_wait_i;
        end
      end
      ST_XTAL: begin
        if (tmr_zero_i) begin
          st_d = ST_SYNTH; tmr_load_o = 1'b1; tmr_val_o = pll_wait_i;
        end else tmr_dec_o = 1'b1;
      end
      ST_SYNTH: begin
        if (tmr_zero_i) st_d = rxm_q ? ST_LISTEN : ST_TX_KICK;
        else            tmr_dec_o = 1'b1;
      end
      ST_TX_KICK: st_d = ST_TX_WAIT;
      ST_TX_WAIT: begin
        if (tx_done_i) begin
          st_d = ST_ACK_WAIT; tmr_load_o = 1'b1; tmr_val_o = ack_wait_i;
        end
      end
      ST_ACK_WAIT: begin
        // an ack in the last window cycle still counts
        if (rx_ack_i)        begin st_d = rest_st; ev_ack_o = 1'b1; end
        else if (tmr_zero_i) begin st_d = rest_st; ev_to_o  = 1'b1; end
        else tmr_dec_o = 1'b1;
      end
      ST_LISTEN: begin
        if (!rx_mode_i)    st_d = rest_st;
        else if (rx_pkt_i) begin st_d = ST_ACK_KICK; ev_pkt_o = 1'b1; end
      end
      ST_ACK_KICK: st_d = ST_ACK_SEND;
      ST_ACK_SEND: if (tx_done_i) st_d = ST_LISTEN;
      default: st_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SLEEP;
      rxm_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rxm_q <= rxm_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/ack_seq_flags.sv
module ack_seq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_go_i,
  input  logic ev_ack_i,
  input  logic ev_to_i,
  input  logic ev_pkt_i,
  output logic ack_ok_o,
  output logic timeout_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_ok_o  <= 1'b0;
      timeout_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= ev_pkt_i;
      if (ev_go_i) begin
        ack_ok_o  <= 1'b0;
        timeout_o <= 1'b0;
      end else begin
        if (ev_ack_i) ack_ok_o  <= 1'b1;
        if (ev_to_i)  timeout_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ack_txn_seq.sv
module ack_txn_seq
  import ack_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             rx_mode_i,
  input  logic             end_idle_i,
  input  logic [CNT_W-1:0] osc_wait_i,
  input  logic [CNT_W-1:0] pll_wait_i,
  input  logic [CNT_W-1:0] ack_wait_i,
  input  logic             tx_done_i,
  input  logic             rx_ack_i,
  input  logic             rx_pkt_i,
  input  logic             rx_byte_vld_i,
  output logic             xtal_en_o,
  output logic             synth_en_o,
  output logic             tx_req_o,
  output logic             tx_ack_sel_o,
  output logic             rx_en_o,
  output logic             rx_buf_we_o,
  output logic             busy_o,
  output logic             sleep_o,
  output logic             ack_ok_o,
  output logic             timeout_o,
  output logic             irq_o
);
  seq_st_e          st;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             ev_go, ev_ack, ev_to, ev_pkt;

  ack_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .go_i, .rx_mode_i, .end_idle_i,
    .osc_wait_i, .pll_wait_i, .ack_wait_i,
    .tx_done_i, .rx_ack_i, .rx_pkt_i,
    .tmr_zero_i (tmr_zero),
    .st_o       (st),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_dec_o  (tmr_dec),
    .ev_go_o    (ev_go),
    .ev_ack_o   (ev_ack),
    .ev_to_o    (ev_to),
    .ev_pkt_o   (ev_pkt)
  );

  ack_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  ack_seq_flags u_flags (
    .clk_i, .rst_ni,
    .ev_go_i  (ev_go),
    .ev_ack_i (ev_ack),
    .ev_to_i  (ev_to),
    .ev_pkt_i (ev_pkt),
    .ack_ok_o, .timeout_o, .irq_o
  );

  assign sleep_o      = (st == ST_SLEEP);
  assign busy_o       = !(st inside {ST_SLEEP, ST_IDLE});
  assign xtal_en_o    = busy_o;
  assign synth_en_o   = busy_o && (st != ST_XTAL);
  assign tx_req_o     = (st == ST_TX_KICK) || (st == ST_ACK_KICK);
  assign tx_ack_sel_o = (st == ST_ACK_KICK) || (st == ST_ACK_SEND);
  assign rx_en_o      = (st == ST_ACK_WAIT) || (st == ST_LISTEN);
  assign rx_buf_we_o  = (st == ST_LISTEN) && rx_byte_vld_i;
endmodule

// File: rtl/ack_txn_seq_chk.sv
module ack_txn_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic go_i,
  input logic busy_o,
  input logic xtal_en_o,
  input logic synth_en_o,
  input logic tx_req_o,
  input logic tx_ack_sel_o,
  input logic rx_buf_we_o,
  input logic ack_ok_o,
  input logic timeout_o,
  input logic irq_o
);
  a_r3_kick_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (xtal_en_o && synth_en_o));
  a_r3_kick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);
  a_r5_status_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_ok_o && timeout_o));
  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r9_ack_no_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_sel_o |-> !rx_buf_we_o);
  a_r10_busy_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && go_i && ack_ok_o) |=> ack_ok_o);
endmodule

bind ack_txn_seq ack_txn_seq_chk u_chk (
  .clk_i, .rst_ni, .go_i, .busy_o, .xtal_en_o, .synth_en_o, .tx_req_o,
  .tx_ack_sel_o, .rx_buf_we_o, .ack_ok_o, .timeout_o, .irq_o
);

// File: tb/tb_ack_txn_seq.sv
`timescale 1ns/1ps
module tb_ack_txn_seq;
  localparam int CNT_W = 8;
  localparam int OW = 2, PW = 1, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 0, rx_mode = 0, end_idle = 0, tx_done = 0, rx_ack = 0, rx_pkt = 0, byte_vld = 0;
  logic xtal_en, synth_en, tx_req, tx_ack_sel, rx_en, rx_buf_we, busy, sleep, ack_ok, timeout, irq;
  int n_chk = 0, n_err = 0;
  bit exp_q[$];
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  ack_txn_seq #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .rx_mode_i(rx_mode), .end_idle_i(end_idle),
    .osc_wait_i(CNT_W'(OW)), .pll_wait_i(CNT_W'(PW)), .ack_wait_i(CNT_W'(AW)),
    .tx_done_i(tx_done), .rx_ack_i(rx_ack), .rx_pkt_i(rx_pkt), .rx_byte_vld_i(byte_vld),
    .xtal_en_o(xtal_en), .synth_en_o(synth_en), .tx_req_o(tx_req), .tx_ack_sel_o(tx_ack_sel),
    .rx_en_o(rx_en), .rx_buf_we_o(rx_buf_we), .busy_o(busy), .sleep_o(sleep),
    .ack_ok_o(ack_ok), .timeout_o(timeout), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor: every transmit request must match the next expected source
  always @(negedge clk) begin
    if (rst_n && tx_req) begin
      if (exp_q.size() == 0) chk("R8 unexpected tx_req", 1, 0);
      else chk("R3/R8 tx source select", int'(tx_ack_sel), int'(exp_q.pop_front()));
    end
  end

  task automatic tick(); @(negedge clk); endtask

  // called at first sample after power-up start; returns at tx_req or listen sample
  task automatic powerup(input string req);
    int nx = 0, ns = 0;
    while (xtal_en && !synth_en && nx < 50) begin nx++; tick(); end
    while (synth_en && !tx_req && !rx_en && ns < 50) begin ns++; tick(); end
    chk({req, " osc settle cycles"}, nx, OW + 1);
    chk({req, " pll settle cycles"}, ns, PW + 1);
  endtask

  task automatic pulse_done();
    tx_done = 1; tick(); tx_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int nw;
    repeat (3) tick();
    // R1 reset state
    chk("R1 sleep", sleep, 1);
    chk("R1 busy", busy, 0);
    chk("R1 outputs", {xtal_en, synth_en, rx_en, tx_req, ack_ok, timeout, irq}, 0);
    rst_n = 1; tick();

    // R2/R3/R4/R10: acked transaction, go held high all along
    exp_q.push_back(0);
    go = 1; tick();
    chk("R2 busy", busy, 1);
    chk("R2 xtal_en", xtal_en, 1);
    powerup("R3 R10");
    chk("R3 tx_req", tx_req, 1);
    go = 0; tick();
    chk("R3 single pulse", tx_req, 0);
    pulse_done();
    chk("R4 rx_en in wait", rx_en, 1);
    byte_vld = 1;
    chk("R9 no buffer write in ack wait", rx_buf_we, 0);
    go = 1; tick(); go = 0;
    chk("R10 still waiting", rx_en, 1);
    rx_ack = 1; tick(); rx_ack = 0; byte_vld = 0;
    chk("R4 ack_ok", ack_ok, 1);
    chk("R5 no timeout", timeout, 0);
    chk("R6 sleep end", sleep, 1);
    chk("R6 not busy", busy, 0);

    // R5/R6 timeout ending in idle
    end_idle = 1;
    exp_q.push_back(0);
    go = 1; tick(); go = 0;
    chk("R2 status cleared", ack_ok, 0);
    powerup("R3");
    tick(); pulse_done();
    nw = 0;
    while (rx_en && nw < 50) begin nw++; tick(); end
    chk("R5 wait cycles", nw, AW + 1);
    chk("R5 timeout", timeout, 1);
    chk("R5 ack_ok low", ack_ok, 0);
    chk("R6 idle not sleep", sleep, 0);
    chk("R6 idle not busy", busy, 0);

    // R5 ack on last window cycle
    exp_q.push_back(0);
    go = 1; tick(); go = 0;
    chk("R2 timeout cleared", timeout, 0);
    powerup("R3");
    tick(); pulse_done();
    repeat (AW) tick();
    rx_ack = 1; tick(); rx_ack = 0;
    chk("R5 late ack ok", ack_ok, 1);
    chk("R5 late ack no timeout", timeout, 0);

    // R7/R8/R9/R12 receive transaction mode
    end_idle = 0;
    rx_mode = 1; tick();
    chk("R7 busy", busy, 1);
    powerup("R7");
    chk("R7 listening", rx_en, 1);
    chk("R7 no tx", tx_req, 0);
    byte_vld = 1; #1;
    chk("R9 write while listening", rx_buf_we, 1);
    exp_q.push_back(1);
    rx_pkt = 1; tick(); rx_pkt = 0;
    chk("R8 irq", irq, 1);
    chk("R8 ack tx_req", tx_req, 1);
    chk("R9 no write on ack tx", rx_buf_we, 0);
    tick();
    chk("R8 irq single", irq, 0);
    chk("R8 ack source held", tx_ack_sel, 1);
    chk("R9 no write while sending ack", rx_buf_we, 0);
    pulse_done();
    chk("R8 back to listen", rx_en, 1);
    chk("R8 source released", tx_ack_sel, 0);
    byte_vld = 0;
    rx_mode = 0; tick();
    chk("R12 rest", sleep, 1);
    chk("R12 rx off", rx_en, 0);

    // R11 go beats rx_mode
    exp_q.push_back(0);
    go = 1; rx_mode = 1; tick(); go = 0; rx_mode = 0;
    powerup("R11");
    chk("R11 data tx", tx_req, 1);
    tick(); pulse_done();
    rx_ack = 1; tick(); rx_ack = 0;
    chk("R11 acked", ack_ok, 1);
    tick();
    chk("R8 all requests seen", exp_q.size(), 0);
    finish_run();
  end
endmodule